// File: doc/BRIEF.md
# Call and Trap Context Stack

This block keeps a processor's execution context across subroutine calls, software traps and interrupts. A push stores one context entry: the 16-bit return address, the current global interrupt enable, the four ALU flags (zero, carry, negative, overflow) and the two register-bank select bits. The stack holds twelve such entries, and calls and interrupts share them. The block owns the live interrupt-enable bit and the live bank-select bits. The ALU flags come in from outside. Restored flags go back out as a one-cycle load pulse.

A return pops the top entry and always loads the program counter from it. A two-bit restore code chooses what happens to the interrupt enable: keep it, restore it from the entry, set it, or clear it. A separate flag-restore bit chooses whether the flags and bank selection come back from the entry. A trap pushes context the same way as a call. It then jumps to an address built from the upper byte of an interrupt base register, two zero bits and a 6-bit vector number. A bank exchange request selects the main or alternate bank for bank A and bank B independently, and it can also set or clear the interrupt enable.

Only one operation takes effect per cycle. All outputs are registered and appear one clock after the request.

Top module: `ctx_stack`

## Requirements
- R1: After synchronous reset, `gie`, `bank_sel`, `pc_load`, `flags_load`, `ovf_err` and `unf_err` are all 0 and the stack is empty.
- R2: A push without `trap_en` stores {`push_pc`, `gie`, `push_flags`, `bank_sel`} and produces no `pc_load`. The pop that matches it, in last-in first-out order, pulses `pc_load` for one cycle with `pc_target` equal to the stored `push_pc`.
- R3: The stack holds exactly 12 entries. A push while 12 entries are held pulses `ovf_err`, gives no `pc_load` and changes no entry. A pop while the stack is empty pulses `unf_err`, gives no `pc_load` and changes neither `gie` nor `bank_sel`.
- R4: The `pop_g` code of a successful pop sets the next `gie` as follows: 0 keeps it, 1 takes the value stored in the entry, 2 sets it to 1, 3 clears it to 0.
- R5: A successful pop with `pop_rf`=1 pulses `flags_load` with `flags_out` = the stored flags {Z,C,N,V} and loads `bank_sel` from the entry. With `pop_rf`=0 there is no `flags_load` pulse and `bank_sel` does not change.
- R6: A push with `trap_en`=1 that is not rejected pulses `pc_load` with `pc_target` = {`int_base_hi`[7:0], 2'b00, `trap_vec`[5:0]}, which covers 64 vectors. It also pushes the context as in R2.
- R7: A trap with `trap_clr_gie`=1 clears `gie` after it pushes the old value. With `trap_clr_gie`=0 the trap leaves `gie` unchanged.
- R8: A bank exchange loads `bank_sel` from `exx_bank` (bit 1 selects bank A, bit 0 selects bank B, 1 = alternate). Its `exx_g` code means 0 keep, 2 set, 3 clear, and 1 (reserved) keeps `gie` unchanged.
- R9: Requests have the priority push over pop over bank exchange. A lower request in the same cycle is ignored completely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_req | input | 1 | Push a context entry (call, trap or interrupt) |
| push_pc | input | 16 | Return address to save |
| push_flags | input | 4 | Current ALU flags {Z,C,N,V} |
| trap_en | input | 1 | Push is a trap: jump to the vector address |
| trap_vec | input | 6 | Trap vector number |
| trap_clr_gie | input | 1 | Trap clears the interrupt enable |
| int_base_hi | input | 8 | Upper byte of the interrupt base register |
| pop_req | input | 1 | Return: pop the top entry |
| pop_g | input | 2 | Interrupt-enable action on return |
| pop_rf | input | 1 | Restore flags and bank selection on return |
| exx_req | input | 1 | Bank exchange request |
| exx_bank | input | 2 | New bank selection {A,B} |
| exx_g | input | 2 | Interrupt-enable action on exchange |
| pc_load | output | 1 | One-cycle pulse: load the program counter |
| pc_target | output | 16 | Program counter value to load |
| gie | output | 1 | Live global interrupt enable |
| bank_sel | output | 2 | Live bank selection {A,B} |
| flags_load | output | 1 | One-cycle pulse: load the ALU flags |
| flags_out | output | 4 | Restored flags {Z,C,N,V} |
| ovf_err | output | 1 | Push rejected because the stack is full |
| unf_err | output | 1 | Pop rejected because the stack is empty |

## Verification
A push can arrive in the same cycle as a return or a bank exchange, and a return can arrive together with an exchange. All three can also be requested at once. The bench drives these combinations both on a partly filled stack and on a full one. A push on a full stack still wins and leaves the pop unserved. Each such cycle is judged against a bench model that applies only the winning request: the level, `gie` and `bank_sel` must match it, and `pc_load` and the error pulses must match that single operation.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

  localparam int PC_W   = 16;
  localparam int FLAG_W = 4;
  localparam int BANK_W = 2;
  localparam int VEC_W  = 6;
  localparam int BASE_W = 8;

  typedef struct packed {
    logic [PC_W-1:0]   pc;
    logic              gie;
    logic [FLAG_W-1:0] flags;
    logic [BANK_W-1:0] bank;
  } ctx_entry_t;

  localparam int ENTRY_W = $bits(ctx_entry_t);

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_PUSH = 3'd1,
    OP_POP  = 3'd2,
    OP_EXX  = 3'd3,
    OP_OVF  = 3'd4,
    OP_UNF  = 3'd5
  } ctx_op_e;

  typedef enum logic [1:0] {
    G_KEEP   = 2'd0,
    G_STACK  = 2'd1,
    G_SET    = 2'd2,
    G_CLEAR  = 2'd3
  } gie_code_e;

endpackage

// File: rtl/ctx_lifo.sv
module ctx_lifo #(
  parameter int DEPTH = 12,
  parameter int WIDTH = 23,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] top_data,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] top_idx;

  assign full    = (level == LVL_W'(DEPTH));
  assign empty   = (level == '0);
  assign wr_idx  = IDX_W'(level);
  assign top_idx = empty ? '0 : IDX_W'(level - LVL_W'(1));

  // storage has no reset so it maps onto plain RAM
  always_ff @(posedge clk) begin
    if (wr_en && !full) mem[wr_idx] <= wr_data;
  end

  assign top_data = mem[top_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= '0;
    end else if (wr_en && !full) begin
      level <= level + LVL_W'(1);
    end else if (rd_en && !empty) begin
      level <= level - LVL_W'(1);
    end
  end

endmodule

// File: rtl/ctx_arb.sv
module ctx_arb
  import ctx_pkg::*;
(
  input  logic    push_req,
  input  logic    pop_req,
  input  logic    exx_req,
  input  logic    full,
  input  logic    empty,
  output ctx_op_e op
);

  always_comb begin
    op = OP_NONE;
    if (push_req)     op = full  ? OP_OVF : OP_PUSH;
    else if (pop_req) op = empty ? OP_UNF : OP_POP;
    else if (exx_req) op = OP_EXX;
  end

endmodule

// File: rtl/ctx_gie_sel.sv
module ctx_gie_sel
  import ctx_pkg::*;
(
  input  ctx_op_e    op,
  input  logic       cur_gie,
  input  logic       saved_gie,
  input  logic       trap_en,
  input  logic       trap_clr,
  input  logic [1:0] ret_g,
  input  logic [1:0] exx_g,
  output logic       nxt_gie
);

  always_comb begin
    nxt_gie = cur_gie;
    unique case (op)
      OP_PUSH: if (trap_en && trap_clr) nxt_gie = 1'b0;
      OP_POP: begin
        unique case (gie_code_e'(ret_g))
          G_KEEP:  nxt_gie = cur_gie;
          G_STACK: nxt_gie = saved_gie;
          G_SET:   nxt_gie = 1'b1;
          G_CLEAR: nxt_gie = 1'b0;
        endcase
      end
      OP_EXX: begin
        unique case (gie_code_e'(exx_g))
          G_SET:   nxt_gie = 1'b1;
          G_CLEAR: nxt_gie = 1'b0;
          default: nxt_gie = cur_gie;
        endcase
      end
      default: nxt_gie = cur_gie;
    endcase
  end

endmodule

// File: rtl/ctx_stack.sv
module ctx_stack
  import ctx_pkg::*;
#(
  parameter int DEPTH = 12,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int PAD_W = PC_W - BASE_W - VEC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_req,
  input  logic [PC_W-1:0]   push_pc,
  input  logic [FLAG_W-1:0] push_flags,
  input  logic              trap_en,
  input  logic [VEC_W-1:0]  trap_vec,
  input  logic              trap_clr_gie,
  input  logic [BASE_W-1:0] int_base_hi,
  input  logic              pop_req,
  input  logic [1:0]        pop_g,
  input  logic              pop_rf,
  input  logic              exx_req,
  input  logic [BANK_W-1:0] exx_bank,
  input  logic [1:0]        exx_g,
  output logic              pc_load,
  output logic [PC_W-1:0]   pc_target,
  output logic              gie,
  output logic [BANK_W-1:0] bank_sel,
  output logic              flags_load,
  output logic [FLAG_W-1:0] flags_out,
  output logic              ovf_err,
  output logic              unf_err
);

  ctx_op_e             op;
  ctx_entry_t          wr_entry;
  ctx_entry_t          top_entry;
  logic [ENTRY_W-1:0]  top_raw;
  logic [LVL_W-1:0]    level;
  logic                full;
  logic                empty;
  logic                nxt_gie;
  logic [PC_W-1:0]     trap_addr;

  assign wr_entry  = '{pc: push_pc, gie: gie, flags: push_flags, bank: bank_sel};
  assign top_entry = ctx_entry_t'(top_raw);
  assign trap_addr = {int_base_hi, {PAD_W{1'b0}}, trap_vec};

  ctx_arb u_arb (
    .push_req (push_req),
    .pop_req  (pop_req),
    .exx_req  (exx_req),
    .full     (full),
    .empty    (empty),
    .op       (op)
  );

  ctx_lifo #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_lifo (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (op == OP_PUSH),
    .wr_data  (wr_entry),
    .rd_en    (op == OP_POP),
    .top_data (top_raw),
    .level    (level),
    .full     (full),
    .empty    (empty)
  );

  ctx_gie_sel u_gie (
    .op        (op),
    .cur_gie   (gie),
    .saved_gie (top_entry.gie),
    .trap_en   (trap_en),
    .trap_clr  (trap_clr_gie),
    .ret_g     (pop_g),
    .exx_g     (exx_g),
    .nxt_gie   (nxt_gie)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_load    <= 1'b0;
      pc_target  <= '0;
      gie        <= 1'b0;
      bank_sel   <= '0;
      flags_load <= 1'b0;
      flags_out  <= '0;
      ovf_err    <= 1'b0;
      unf_err    <= 1'b0;
    end else begin
      pc_load    <= 1'b0;
      flags_load <= 1'b0;
      ovf_err    <= (op == OP_OVF);
      unf_err    <= (op == OP_UNF);
      gie        <= nxt_gie;
      unique case (op)
        OP_PUSH: begin
          if (trap_en) begin
            pc_load   <= 1'b1;
            pc_target <= trap_addr;
          end
        end
        OP_POP: begin
          pc_load   <= 1'b1;
          pc_target <= top_entry.pc;
          if (pop_rf) begin
            flags_load <= 1'b1;
            flags_out  <= top_entry.flags;
            bank_sel   <= top_entry.bank;
          end
        end
        OP_EXX:  bank_sel <= exx_bank;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ctx_stack_chk.sv
module ctx_stack_chk
  import ctx_pkg::*;
#(
  parameter int DEPTH = 12,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              push_req,
  input logic              trap_en,
  input logic [VEC_W-1:0]  trap_vec,
  input logic              pop_req,
  input logic [1:0]        pop_g,
  input logic              pop_rf,
  input logic              pc_load,
  input logic [PC_W-1:0]   pc_target,
  input logic              gie,
  input logic [BANK_W-1:0] bank_sel,
  input logic              flags_load,
  input logic              ovf_err,
  input logic              unf_err,
  input logic [LVL_W-1:0]  level,
  input logic              full,
  input logic              empty
);

  p_ovf_reject_r3: assert property (@(posedge clk) disable iff (rst)
    (push_req && full) |=> (ovf_err && !pc_load && level == $past(level)));

  p_unf_reject_r3: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !push_req && empty) |=> (unf_err && !pc_load && $stable(bank_sel)));

  p_level_cap_r3: assert property (@(posedge clk) disable iff (rst)
    level <= LVL_W'(DEPTH));

  p_call_no_jump_r2: assert property (@(posedge clk) disable iff (rst)
    (push_req && !trap_en) |=> !pc_load);

  p_pop_jumps_r2: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !push_req && !empty) |=> (pc_load && level == $past(level) - LVL_W'(1)));

  p_gie_set_r4: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !push_req && !empty && pop_g == 2'd2) |=> gie);

  p_gie_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !push_req && !empty && pop_g == 2'd3) |=> !gie);

  p_no_restore_r5: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !push_req && !pop_rf) |=> (!flags_load && $stable(bank_sel)));

  p_trap_addr_r6: assert property (@(posedge clk) disable iff (rst)
    (push_req && trap_en && !full) |=>
      (pc_load && pc_target[7:6] == 2'b00 && pc_target[5:0] == $past(trap_vec)));

  p_push_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (push_req && pop_req && !full) |=> (!unf_err && level == $past(level) + LVL_W'(1)));

  p_err_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
    !(ovf_err && unf_err));

endmodule

bind ctx_stack ctx_stack_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .push_req   (push_req),
  .trap_en    (trap_en),
  .trap_vec   (trap_vec),
  .pop_req    (pop_req),
  .pop_g      (pop_g),
  .pop_rf     (pop_rf),
  .pc_load    (pc_load),
  .pc_target  (pc_target),
  .gie        (gie),
  .bank_sel   (bank_sel),
  .flags_load (flags_load),
  .ovf_err    (ovf_err),
  .unf_err    (unf_err),
  .level      (level),
  .full       (full),
  .empty      (empty)
);

// File: tb/ctx_stack_test.sv
`timescale 1ns/100ps
module ctx_stack_test;

  localparam int DEPTH = 12;

  logic        clk = 1'b0;
  logic        rst;
  logic        push_req, trap_en, trap_clr_gie, pop_req, pop_rf, exx_req;
  logic [15:0] push_pc;
  logic [3:0]  push_flags;
  logic [5:0]  trap_vec;
  logic [7:0]  int_base_hi;
  logic [1:0]  pop_g, exx_bank, exx_g;
  logic        pc_load, gie, flags_load, ovf_err, unf_err;
  logic [15:0] pc_target;
  logic [1:0]  bank_sel;
  logic [3:0]  flags_out;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  // bench model
  logic [15:0] m_pc [DEPTH];
  logic        m_g  [DEPTH];
  logic [3:0]  m_fl [DEPTH];
  logic [1:0]  m_bk [DEPTH];
  int          m_cnt  = 0;
  logic        m_gie  = 1'b0;
  logic [1:0]  m_bank = 2'b00;
  int unsigned seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  ctx_stack #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst),
    .push_req(push_req), .push_pc(push_pc), .push_flags(push_flags),
    .trap_en(trap_en), .trap_vec(trap_vec), .trap_clr_gie(trap_clr_gie),
    .int_base_hi(int_base_hi),
    .pop_req(pop_req), .pop_g(pop_g), .pop_rf(pop_rf),
    .exx_req(exx_req), .exx_bank(exx_bank), .exx_g(exx_g),
    .pc_load(pc_load), .pc_target(pc_target), .gie(gie), .bank_sel(bank_sel),
    .flags_load(flags_load), .flags_out(flags_out),
    .ovf_err(ovf_err), .unf_err(unf_err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      total = total + 1;
      bad   = bad + 1;
      $display("FAIL watchdog: act=%0d cycles exp=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s %s: act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    push_req = 0; trap_en = 0; trap_clr_gie = 0; pop_req = 0; pop_rf = 0;
    exx_req = 0; push_pc = '0; push_flags = '0; trap_vec = '0;
    int_base_hi = '0; pop_g = '0; exx_bank = '0; exx_g = '0;
  endtask

  // one request cycle: drive after an edge, check after the next edge
  task automatic cycle(input bit pu, input bit po, input bit ex,
                       input logic [15:0] pc, input logic [3:0] fl,
                       input bit tr, input logic [5:0] vec, input bit clr,
                       input logic [7:0] base, input logic [1:0] rg,
                       input bit rf, input logic [1:0] xb, input logic [1:0] xg);
    bit          e_load = 0, e_fload = 0, e_ovf = 0, e_unf = 0;
    logic [15:0] e_tgt = '0;
    logic [3:0]  e_fl = '0;
    string       t_pc, t_gie, t_bank;
    bool_sel: begin end
    push_req = pu; pop_req = po; exx_req = ex; push_pc = pc; push_flags = fl;
    trap_en = tr; trap_vec = vec; trap_clr_gie = clr; int_base_hi = base;
    pop_g = rg; pop_rf = rf; exx_bank = xb; exx_g = xg;
    t_pc = "R2"; t_gie = "R4"; t_bank = "R5";
    if (pu) begin
      t_gie = "R7"; t_bank = "R2";
      if (m_cnt == DEPTH) begin
        e_ovf = 1; t_pc = "R3";
      end else begin
        m_pc[m_cnt] = pc; m_g[m_cnt] = m_gie; m_fl[m_cnt] = fl; m_bk[m_cnt] = m_bank;
        m_cnt = m_cnt + 1;
        if (tr) begin
          e_load = 1; e_tgt = {base, 2'b00, vec}; t_pc = "R6";
          if (clr) m_gie = 1'b0;
        end
      end
    end else if (po) begin
      if (m_cnt == 0) begin
        e_unf = 1; t_pc = "R3"; t_gie = "R3"; t_bank = "R3";
      end else begin
        m_cnt = m_cnt - 1;
        e_load = 1; e_tgt = m_pc[m_cnt];
        case (rg)
          2'd1: m_gie = m_g[m_cnt];
          2'd2: m_gie = 1'b1;
          2'd3: m_gie = 1'b0;
          default: ;
        endcase
        if (rf) begin
          e_fload = 1; e_fl = m_fl[m_cnt]; m_bank = m_bk[m_cnt];
        end
      end
    end else if (ex) begin
      t_gie = "R8"; t_bank = "R8";
      m_bank = xb;
      if (xg == 2'd2) m_gie = 1'b1;
      if (xg == 2'd3) m_gie = 1'b0;
    end
    if ((pu && (po || ex)) || (po && ex)) begin
      t_pc = "R9"; t_gie = "R9"; t_bank = "R9";
    end
    @(posedge clk);
    #1;
    chk(pc_load == e_load, t_pc, "pc_load", 32'(pc_load), 32'(e_load));
    if (e_load) chk(pc_target == e_tgt, t_pc, "pc_target", 32'(pc_target), 32'(e_tgt));
    chk(gie == m_gie, t_gie, "gie", 32'(gie), 32'(m_gie));
    chk(bank_sel == m_bank, t_bank, "bank_sel", 32'(bank_sel), 32'(m_bank));
    chk(flags_load == e_fload, "R5", "flags_load", 32'(flags_load), 32'(e_fload));
    if (e_fload) chk(flags_out == e_fl, "R5", "flags_out", 32'(flags_out), 32'(e_fl));
    chk(ovf_err == e_ovf, "R3", "ovf_err", 32'(ovf_err), 32'(e_ovf));
    chk(unf_err == e_unf, "R3", "unf_err", 32'(unf_err), 32'(e_unf));
    idle_inputs();
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  initial begin
    idle_inputs();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    // R1 reset state
    chk(gie == 1'b0, "R1", "gie", 32'(gie), 0);
    chk(bank_sel == 2'b00, "R1", "bank_sel", 32'(bank_sel), 0);
    chk(pc_load == 1'b0, "R1", "pc_load", 32'(pc_load), 0);
    chk(flags_load == 1'b0, "R1", "flags_load", 32'(flags_load), 0);
    chk(ovf_err == 1'b0 && unf_err == 1'b0, "R1", "errors",
        32'({ovf_err, unf_err}), 0);
    // R1: empty after reset, so a pop underflows (R3)
    cycle(0, 1, 0, '0, '0, 0, '0, 0, '0, 2'd2, 1, '0, '0);

    // R8 exchange sweep: every bank pair with every g code
    for (int i = 0; i < 16; i++)
      cycle(0, 0, 1, '0, '0, 0, '0, 0, '0, '0, 0, 2'(i), 2'(i >> 2));

    // fill: calls and traps mixed, vary live context (R2 R6 R7)
    for (int i = 0; i < DEPTH; i++) begin
      cycle(0, 0, 1, '0, '0, 0, '0, 0, '0, '0, 0, 2'(i * 3), (i % 3 == 0) ? 2'd3 : 2'd2);
      cycle(1, 0, 0, 16'h1000 + 16'(i * 16'h0111), 4'(i + 5), i[0], 6'(i * 5 + 1),
            i[1], 8'(8'hA0 + i), '0, 0, '0, '0);
    end
    // R3 overflow: twice, also as a trap and with a pop beside it (R9)
    cycle(1, 0, 0, 16'hDEAD, 4'hF, 1, 6'h3F, 1, 8'hFF, '0, 0, '0, '0);
    cycle(1, 1, 1, 16'hBEEF, 4'hE, 0, 6'h00, 0, 8'h00, 2'd2, 1, 2'b11, 2'd2);

    // drain with every g code and rf value (R2 R4 R5)
    for (int i = 0; i < DEPTH; i++)
      cycle(0, 1, 0, '0, '0, 0, '0, 0, '0, 2'(i), (i % 3) != 1, '0, '0);
    // R3 underflow twice
    cycle(0, 1, 0, '0, '0, 0, '0, 0, '0, 2'd1, 1, '0, '0);
    cycle(0, 1, 1, '0, '0, 0, '0, 0, '0, 2'd3, 0, 2'b10, 2'd2);

    // R9 priority combinations on a part-filled stack
    for (int i = 0; i < 8; i++)
      cycle(i[0] | i[1], i[1] | i[2], 1, 16'h4000 + 16'(i), 4'(i), i[2], 6'(i), 1,
            8'h5A, 2'(i), i[0], 2'(3 - (i % 4)), 2'(i % 4));

    // R2..R9 pseudo-random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = rnd();
      cycle(r[3:2] == 2'b00 || r[3:2] == 2'b11, r[3:2] == 2'b01 || r[12], r[3:2] == 2'b10 || r[13],
            r[31:16], r[7:4], r[8], r[21:16], r[9], r[29:22], r[11:10], r[14], r[15:14], r[1:0]);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule